// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block takes a four-bank synchronous DRAM from power-up to a usable state. After a synchronous reset it holds the command pins idle for a stabilization interval that is set by a parameter. It then closes every bank with a single precharge-all and issues exactly two auto-refresh commands. Last, it writes a mode word that is fixed by a parameter into the mode register. Each of these commands is followed by a timed run of NOP cycles, and every wait length is a parameter given in clock cycles.

All outputs come straight from flip-flops clocked on the rising edge. Once the mode-register wait has run out, the sequencer raises `ready` and from then on drives only NOP. A downstream memory controller uses `ready` to take the command pins over. Read and write traffic, periodic refresh and the data bus belong to that controller, not to this block.

Top module: `sdram_bringup_seq`

## Requirements
- R1: While `rst` is high at a rising edge, the outputs take `cs_n`=1 (command inhibit), `ready`=0 and `cke`=1.
- R2: Cycles are counted from the first cycle after `rst` falls as cycle 0. Cycle 0 shows inhibit, left over from reset. Cycles 1 to STABLE_CYCLES-1 show NOP, where {cs_n,ras_n,cas_n,we_n}=0111. No other command appears before cycle STABLE_CYCLES.
- R3: In cycle STABLE_CYCLES the pins carry precharge (0010) with `addr[10]`=1 to select all banks. No auto-refresh has been issued before it.
- R4: After the precharge come TRP_CYCLES cycles of NOP, and then one auto-refresh (0001).
- R5: After the first refresh come TRFC_CYCLES cycles of NOP, a second auto-refresh, and another TRFC_CYCLES cycles of NOP.
- R6: The next cycle carries load-mode-register (0000) with `addr`=MODE_WORD and `ba`=0. Exactly two refreshes have been issued before it.
- R7: After the mode load come TMRD_CYCLES cycles of NOP. In the cycle after those, `ready` rises. From then on it stays high, and the pins show only NOP until the next reset.
- R8: `cke` is 1 in every cycle.
- R9: A reset at any point, including after `ready`, drops `ready` and restarts the whole bring-up from cycle 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| cke | output | 1 | Clock enable to the memory |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | BANK_W | Bank address |
| addr | output | ADDR_W | Address bus (A10 selects all banks on precharge) |
| ready | output | 1 | Bring-up complete, controller may take over |

## Verification
A fault in the step register or the wait counter shows up at the pins as a command in the wrong cycle. Typical cases are a precharge that comes one cycle early or late, a refresh that is skipped or repeated, or a mode load that appears before the second refresh. Any of these is visible in the very cycle in which the schedule first departs from the expected one. For that reason the bench compares every pin in every cycle against a timeline that it computes from the four wait parameters. A `ready` flag that is stuck, or that falls after it has risen, shows up in the first cycle that departs from the expected schedule.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

  typedef enum logic [3:0] {
    ST_STABLE, ST_PRE, ST_TRP, ST_REF1, ST_TRFC1,
    ST_REF2, ST_TRFC2, ST_MRS, ST_TMRD, ST_DONE
  } init_step_e;

  // {cs_n, ras_n, cas_n, we_n}
  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } cmd_pins_t;

  localparam cmd_pins_t PINS_INHIBIT = 4'b1111;
  localparam cmd_pins_t PINS_NOP     = 4'b0111;
  localparam cmd_pins_t PINS_PRE     = 4'b0010;
  localparam cmd_pins_t PINS_REF     = 4'b0001;
  localparam cmd_pins_t PINS_MRS     = 4'b0000;

  function automatic cmd_pins_t step_pins(init_step_e s);
    case (s)
      ST_PRE:           return PINS_PRE;
      ST_REF1, ST_REF2: return PINS_REF;
      ST_MRS:           return PINS_MRS;
      default:          return PINS_NOP;
    endcase
  endfunction

  function automatic logic step_issues(init_step_e s);
    return (s == ST_PRE) || (s == ST_REF1) || (s == ST_REF2) || (s == ST_MRS);
  endfunction

  function automatic logic step_waits(init_step_e s);
    return (s == ST_STABLE) || (s == ST_TRP) || (s == ST_TRFC1) ||
           (s == ST_TRFC2) || (s == ST_TMRD);
  endfunction

endpackage

// File: rtl/sdram_step_timer.sv
module sdram_step_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic [CNT_W-1:0] limit,
  output logic             last
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || restart) cnt_q <= '0;
    else                cnt_q <= cnt_q + CNT_W'(1);
  end

  // final cycle of a wait lasting `limit` cycles
  assign last = (cnt_q == limit - CNT_W'(1));

endmodule

// File: rtl/sdram_cmd_drive.sv
module sdram_cmd_drive
  import sdram_init_pkg::*;
#(
  parameter int                ADDR_W    = 12,
  parameter int                BANK_W    = 2,
  parameter logic [ADDR_W-1:0] MODE_WORD = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  init_step_e        step_next,
  output logic              cke,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [BANK_W-1:0] ba,
  output logic [ADDR_W-1:0] addr,
  output logic              ready
);
  localparam int ALL_BANK_BIT = 10;

  function automatic logic [ADDR_W-1:0] step_addr(init_step_e s);
    logic [ADDR_W-1:0] a;
    a = '0;
    if (s == ST_PRE) a[ALL_BANK_BIT] = 1'b1;
    if (s == ST_MRS) a = MODE_WORD;
    return a;
  endfunction

  cmd_pins_t pins_d;
  assign pins_d = step_pins(step_next);

  always_ff @(posedge clk) begin
    if (rst) begin
      {cs_n, ras_n, cas_n, we_n} <= PINS_INHIBIT;
      ba    <= '0;
      addr  <= '0;
      cke   <= 1'b1;
      ready <= 1'b0;
    end else begin
      {cs_n, ras_n, cas_n, we_n} <= pins_d;
      ba    <= '0;
      addr  <= step_addr(step_next);
      cke   <= 1'b1;
      ready <= (step_next == ST_DONE);
    end
  end

endmodule

// File: rtl/sdram_bringup_seq.sv
module sdram_bringup_seq
  import sdram_init_pkg::*;
#(
  parameter int                STABLE_CYCLES = 50000,
  parameter int                TRP_CYCLES    = 3,
  parameter int                TRFC_CYCLES   = 16,
  parameter int                TMRD_CYCLES   = 2,
  parameter int                ADDR_W        = 12,
  parameter int                BANK_W        = 2,
  parameter logic [ADDR_W-1:0] MODE_WORD     = 12'h032
) (
  input  logic              clk,
  input  logic              rst,
  output logic              cke,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [BANK_W-1:0] ba,
  output logic [ADDR_W-1:0] addr,
  output logic              ready
);
  localparam int MAX_A    = (STABLE_CYCLES > TRP_CYCLES) ? STABLE_CYCLES : TRP_CYCLES;
  localparam int MAX_B    = (TRFC_CYCLES > TMRD_CYCLES) ? TRFC_CYCLES : TMRD_CYCLES;
  localparam int MAX_WAIT = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W    = $clog2(MAX_WAIT + 1);

  init_step_e       step_q, step_d;
  logic [CNT_W-1:0] wait_limit;
  logic             tmr_last, tmr_restart;

  always_comb begin
    case (step_q)
      ST_STABLE:          wait_limit = CNT_W'(STABLE_CYCLES);
      ST_TRP:             wait_limit = CNT_W'(TRP_CYCLES);
      ST_TRFC1, ST_TRFC2: wait_limit = CNT_W'(TRFC_CYCLES);
      ST_TMRD:            wait_limit = CNT_W'(TMRD_CYCLES);
      default:            wait_limit = CNT_W'(1);
    endcase
  end

  assign tmr_restart = step_issues(step_q) || (step_q == ST_DONE) ||
                       (step_waits(step_q) && tmr_last);

  always_comb begin
    step_d = step_q;
    case (step_q)
      ST_STABLE: if (tmr_last) step_d = ST_PRE;
      ST_PRE:                  step_d = ST_TRP;
      ST_TRP:    if (tmr_last) step_d = ST_REF1;
      ST_REF1:                 step_d = ST_TRFC1;
      ST_TRFC1:  if (tmr_last) step_d = ST_REF2;
      ST_REF2:                 step_d = ST_TRFC2;
      ST_TRFC2:  if (tmr_last) step_d = ST_MRS;
      ST_MRS:                  step_d = ST_TMRD;
      ST_TMRD:   if (tmr_last) step_d = ST_DONE;
      default:                 step_d = ST_DONE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) step_q <= ST_STABLE;
    else     step_q <= step_d;
  end

  sdram_step_timer #(.CNT_W(CNT_W)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .restart (tmr_restart),
    .limit   (wait_limit),
    .last    (tmr_last)
  );

  sdram_cmd_drive #(
    .ADDR_W    (ADDR_W),
    .BANK_W    (BANK_W),
    .MODE_WORD (MODE_WORD)
  ) u_drive (
    .clk       (clk),
    .rst       (rst),
    .step_next (step_d),
    .cke       (cke),
    .cs_n      (cs_n),
    .ras_n     (ras_n),
    .cas_n     (cas_n),
    .we_n      (we_n),
    .ba        (ba),
    .addr      (addr),
    .ready     (ready)
  );

  // ---- port-level events observed by the assertions ----
  logic       evt_nop, evt_pre, evt_ref, evt_mrs;
  logic [1:0] refs_seen_q;

  assign evt_nop = ({cs_n, ras_n, cas_n, we_n} == 4'b0111);
  assign evt_pre = ({cs_n, ras_n, cas_n, we_n} == 4'b0010);
  assign evt_ref = ({cs_n, ras_n, cas_n, we_n} == 4'b0001);
  assign evt_mrs = ({cs_n, ras_n, cas_n, we_n} == 4'b0000);

  always_ff @(posedge clk) begin
    if (rst)                              refs_seen_q <= 2'd0;
    else if (evt_ref && refs_seen_q != 2'd3) refs_seen_q <= refs_seen_q + 2'd1;
  end

  assert_nop_before_pre_R2: assert property (@(posedge clk) disable iff (rst)
    evt_pre |-> $past(evt_nop));
  assert_pre_all_banks_R3: assert property (@(posedge clk) disable iff (rst)
    evt_pre |-> (addr[10] && refs_seen_q == 2'd0));
  assert_nop_before_ref_R4: assert property (@(posedge clk) disable iff (rst)
    evt_ref |-> $past(evt_nop));
  assert_mrs_after_two_refs_R6: assert property (@(posedge clk) disable iff (rst)
    evt_mrs |-> (refs_seen_q == 2'd2 && ba == '0 && addr == MODE_WORD));
  assert_ready_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    ready |=> ready);
  assert_ready_idle_R7: assert property (@(posedge clk) disable iff (rst)
    ready |-> evt_nop);

endmodule

// File: tb/sdram_bringup_seq_bench.sv
`timescale 1ns/1ps
module sdram_bringup_seq_bench;
  localparam int          N    = 20;
  localparam int          TRP  = 2;
  localparam int          TRFC = 5;
  localparam int          TMRD = 3;
  localparam logic [11:0] MODE = 12'h032;

  localparam int PC  = N;
  localparam int R1C = PC + TRP + 1;
  localparam int R2C = R1C + TRFC + 1;
  localparam int MC  = R2C + TRFC + 1;
  localparam int DC  = MC + TMRD + 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cke, cs_n, ras_n, cas_n, we_n, ready;
  logic [1:0]  ba;
  logic [11:0] addr;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  sdram_bringup_seq #(
    .STABLE_CYCLES(N), .TRP_CYCLES(TRP), .TRFC_CYCLES(TRFC), .TMRD_CYCLES(TMRD),
    .ADDR_W(12), .BANK_W(2), .MODE_WORD(MODE)
  ) u_sdram_bringup_seq (
    .clk(clk), .rst(rst), .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .ba(ba), .addr(addr), .ready(ready)
  );

  task automatic check_reset_state(string tag);
    checks++;
    if (!(cs_n == 1'b1 && ready == 1'b0 && cke == 1'b1)) begin
      errors++;
      $display("FAIL %s R1 reset: cs_n=%b ready=%b cke=%b expected cs_n=1 ready=0 cke=1",
               tag, cs_n, ready, cke);
    end
  endtask

  task automatic check_cycle(int c, string tag);
    logic [3:0] ecmd, gcmd;
    logic       eready, ok;
    string      req;
    ecmd   = 4'b0111;
    eready = (c >= DC);
    gcmd   = {cs_n, ras_n, cas_n, we_n};
    if (c < PC)        req = "R2";
    else if (c == PC)  req = "R3";
    else if (c <= R1C) req = "R4";
    else if (c <= R2C) req = "R5";
    else if (c <= MC)  req = "R6";
    else               req = "R7";
    if (c == PC) ecmd = 4'b0010;
    if (c == R1C || c == R2C) ecmd = 4'b0001;
    if (c == MC) ecmd = 4'b0000;
    if (c == 0) ok = (cs_n == 1'b1) && (ready == 1'b0);
    else        ok = (gcmd == ecmd) && (ready == eready);
    if (c == PC) ok = ok && addr[10];
    if (c == MC) ok = ok && (addr == MODE) && (ba == 2'd0);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s cycle %0d: cmd=%b ba=%0d addr=%h ready=%b expected cmd=%b ready=%b%s",
               tag, req, c, gcmd, ba, addr, ready, (c == 0) ? 4'b1111 : ecmd, eready,
               (c == MC) ? " addr=MODE ba=0" : ((c == PC) ? " addr[10]=1" : ""));
    end
    checks++;
    if (cke !== 1'b1) begin  // R8
      errors++;
      $display("FAIL %s R8 cycle %0d: cke=%b expected 1", tag, c, cke);
    end
  endtask

  task automatic hold_reset(int n, string tag);
    @(negedge clk);
    rst = 1'b1;
    repeat (n) @(negedge clk);
    check_reset_state(tag);
  endtask

  task automatic release_and_walk(int last_c, string tag);
    @(negedge clk);
    rst = 1'b0;
    for (int c = 0; c <= last_c; c++) begin
      if (c > 0) @(negedge clk);
      check_cycle(c, tag);
    end
  endtask

  // R1: state held during reset
  task automatic t_reset_state();
    repeat (3) @(negedge clk);
    check_reset_state("t_reset_state");
  endtask

  // R2..R8: full schedule, then idle period after ready
  task automatic t_full_sequence();
    release_and_walk(DC + 40, "t_full_sequence");
  endtask

  // R9: reset in the middle of the refresh waits restarts everything
  task automatic t_mid_reset();
    hold_reset(2, "t_mid_reset_pre");
    release_and_walk(R1C + 2, "t_mid_reset_part");
    hold_reset(2, "t_mid_reset_R9");
    release_and_walk(DC + 3, "t_mid_reset_R9");
  endtask

  // R9: reset after ready drops ready and repeats the bring-up
  task automatic t_reset_after_ready();
    hold_reset(1, "t_after_ready_R9");
    checks++;
    if (ready !== 1'b0) begin
      errors++;
      $display("FAIL R9 ready after reset: ready=%b expected 0", ready);
    end
    release_and_walk(DC + 2, "t_after_ready_R9");
  endtask

  initial begin
    t_reset_state();
    t_full_sequence();
    t_mid_reset();
    t_reset_after_ready();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule